// File: doc/BRIEF.md
# Packet Burst Transmit Initiator

This block moves one packet at a time from a transmit data FIFO to a bus master port that can issue write bursts. Software sets a start address, a burst length and a packet size in bytes. Writing the packet size starts the packet. The block then issues write transactions. Each transaction takes its data words straight from the FIFO head as the master accepts beats. After every transaction the bus reports completion with a one-cycle done pulse.

A transaction of the programmed burst length is started only when the FIFO already holds that many words. Once fewer words remain in the packet than the burst length, the remaining words go out as separate single-beat writes. By default the address advances by the bytes sent in each transaction. A control bit can hold it at the start address for the whole packet. When a packet finishes, the block goes idle and raises a done flag. The next packet continues from the address after the last one used, unless software has written a new start address in between.

Top module: `pkt_burst_tx`

## Requirements
- R1: After reset the block is idle. `busy`, `pkt_done` and `mst_req` are 0, `bytes_left` is 0, `mst_addr` is 0, the burst length is 8 and address increment is enabled.
- R2: The burst length comes from control word bits [3:0]. A value of 0 acts as 1, and a value above 8 acts as 8. Every transaction has a length from 1 to 8, and `mst_be` is all ones.
- R3: The packet size is taken from write data bits [15:0], and bits [1:0] are ignored, so the packet is size/4 words. `bytes_left` shows four times the number of words not yet accepted by the master.
- R4: A transaction of length L is requested only when `fifo_count` is at least L. Until then no request is made.
- R5: When fewer words remain than the burst length, each remaining word is sent as its own transaction of length 1.
- R6: Each transaction uses the current address for all of its beats. After its done pulse the address advances by 4×length. When control bit 4 (hold address) is set, it stays unchanged.
- R7: After the last transaction's done pulse, `pkt_done` rises and `busy` falls in the same cycle. `pkt_done` clears on the next accepted packet-size write.
- R8: A new packet starts at the address following the previous packet's last transaction. A start-address write (select 0, bits [1:0] ignored) made while idle replaces that address.
- R9: A packet size of fewer than 4 bytes makes no request and sets `pkt_done` in the cycle after the write.
- R10: While `busy` is 1, writes to every register select are ignored. The size, length, address and hold bit of the running packet are unchanged.
- R11: The FIFO is popped exactly once per accepted beat. Words leave in FIFO order, and the count of beats equals the packet word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start address, 1 control, 2 packet size |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | A packet is in progress |
| pkt_done | output | 1 | Last packet has completed |
| bytes_left | output | 16 | Bytes of the packet still to be accepted |
| fifo_count | input | 6 | Words currently held in the FIFO |
| fifo_pop | output | 1 | Remove the FIFO head word |
| fifo_data | input | 32 | FIFO head word |
| mst_req | output | 1 | Write transaction in progress |
| mst_addr | output | 32 | Transaction address |
| mst_len | output | 4 | Transaction length in beats |
| mst_wdata | output | 32 | Write data for the current beat |
| mst_be | output | 4 | Byte enables, always all ones |
| mst_beat | input | 1 | Master accepts the current beat |
| mst_done | input | 1 | Master reports the transaction finished |

## Verification
The hardest situation to reach is a packet held in the stall state while software pokes every register. The FIFO is kept short of a full burst, so the packet stays parked. The bench then writes a new address, size and control word and checks that the remaining byte count and later addresses ignore them. A second difficult path is the change from bursts to single-beat tail transactions in the middle of a packet. The bench reaches it with word counts that are not multiples of the burst length. It also covers burst-length field values of 0 and 15, which must clamp, and a master that withholds beats at random points within a burst.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_XFER  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_SIZE = 2'd2;

  localparam int CTRL_HOLD_BIT = 4;
endpackage

// File: rtl/pbt_regs.sv
module pbt_regs
  import pbt_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int MAX_BURST = 8,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              busy,
  output logic [LEN_W-1:0]  blen,
  output logic              hold_addr,
  output logic              size_wr,
  output logic [SIZE_W-3:0] size_words,
  output logic              addr_wr,
  output logic [ADDR_W-1:0] addr_val
);
  localparam int WW = SIZE_W - 2;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [3:0] raw);
    if (raw == 4'd0) return LEN_W'(1);
    if (int'(raw) > MAX_BURST) return LEN_W'(MAX_BURST);
    return LEN_W'(raw);
  endfunction

  logic wr_ok;
  logic ctrl_wr;
  assign wr_ok   = cfg_we && !busy;
  assign ctrl_wr = wr_ok && (cfg_sel == SEL_CTRL);
  assign size_wr = wr_ok && (cfg_sel == SEL_SIZE);
  assign addr_wr = wr_ok && (cfg_sel == SEL_ADDR);

  assign size_words = WW'(cfg_wdata[SIZE_W-1:2]);
  assign addr_val   = {cfg_wdata[ADDR_W-1:2], 2'b00};

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[1:0], cfg_wdata[CFG_W-1:SIZE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen      <= LEN_W'(MAX_BURST);
      hold_addr <= 1'b0;
    end else if (ctrl_wr) begin
      blen      <= clamp_len(cfg_wdata[3:0]);
      hold_addr <= cfg_wdata[CTRL_HOLD_BIT];
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(blen) && $stable(hold_addr)))
    else $error("config changed during packet"); // R10
  AST_BLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (blen != '0) && (int'(blen) <= MAX_BURST))
    else $error("burst length out of range"); // R2
endmodule

// File: rtl/pbt_addr.sv
module pbt_addr #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 8,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              xfer_end,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              hold_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                input logic [LEN_W-1:0]  len,
                                                input logic              hold);
    if (hold) return a;
    return a + (ADDR_W'(len) << 2);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cur_addr <= '0;
    else if (addr_wr)  cur_addr <= addr_val;
    else if (xfer_end) cur_addr <= advance(cur_addr, xfer_len, hold_addr);
  end

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && hold_addr) |=> $stable(cur_addr))
    else $error("address moved with hold set"); // R6
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_end) |=> $stable(cur_addr))
    else $error("address moved inside a transaction"); // R10
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cur_addr[1:0] == 2'b00)
    else $error("address not word aligned"); // R8
endmodule

// File: rtl/pbt_seq.sv
module pbt_seq
  import pbt_pkg::*;
#(
  parameter int SIZE_W    = 16,
  parameter int MAX_BURST = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W     = $clog2(MAX_BURST + 1),
  parameter int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_wr,
  input  logic [SIZE_W-3:0] size_words,
  input  logic [LEN_W-1:0]  blen,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              mst_beat,
  input  logic              mst_done,
  output logic              fifo_pop,
  output logic              mst_req,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_end,
  output logic              busy,
  output logic              pkt_done,
  output logic [SIZE_W-1:0] bytes_left
);
  localparam int WW = SIZE_W - 2;

  function automatic logic [LEN_W-1:0] pick_len(input logic [WW-1:0]    words,
                                                input logic [LEN_W-1:0] bl);
    if (words >= WW'(bl)) return bl;
    return LEN_W'(1);
  endfunction

  seq_state_e        state;
  logic [WW-1:0]     words_left;
  logic [LEN_W-1:0]  beat_cnt;
  logic [LEN_W-1:0]  next_len;
  logic              burst_go;
  logic              beat_take;
  logic              last_beat;

  assign next_len   = pick_len(words_left, blen);
  assign burst_go   = (state == ST_CHECK) && (fifo_count >= CNT_W'(next_len));
  assign mst_req    = (state == ST_XFER);
  assign beat_take  = mst_req && mst_beat;
  assign fifo_pop   = beat_take;
  assign last_beat  = beat_take && (beat_cnt == xfer_len - LEN_W'(1));
  assign xfer_end   = (state == ST_FIN) && mst_done;
  assign busy       = (state != ST_IDLE);
  assign bytes_left = {words_left, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      words_left <= '0;
      beat_cnt   <= '0;
      xfer_len   <= LEN_W'(1);
      pkt_done   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (size_wr) begin
            pkt_done <= (size_words == '0);
            if (size_words != '0) begin
              words_left <= size_words;
              state      <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (burst_go) begin
            xfer_len <= next_len;
            beat_cnt <= '0;
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (beat_take) begin
            words_left <= words_left - WW'(1);
            beat_cnt   <= beat_cnt + LEN_W'(1);
            if (last_beat) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          if (mst_done) begin
            if (words_left == '0) begin
              state    <= ST_IDLE;
              pkt_done <= 1'b1;
            end else begin
              state <= ST_CHECK;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BURST_NEEDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_req) |-> ($past(fifo_count) >= CNT_W'(xfer_len)))
    else $error("burst started without enough FIFO words"); // R4
  AST_TAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mst_req) && (xfer_len != blen)) |-> (xfer_len == LEN_W'(1)))
    else $error("short transaction longer than one beat"); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mst_req |-> ((xfer_len != '0) && (int'(xfer_len) <= MAX_BURST)))
    else $error("transaction length out of range"); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> !busy)
    else $error("done flag while busy"); // R7
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_count != '0))
    else $error("pop from empty FIFO"); // R11
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && $past(mst_req)) |-> $stable(xfer_len))
    else $error("length changed inside a transaction"); // R6
endmodule

// File: rtl/pkt_burst_tx.sv
module pkt_burst_tx
  import pbt_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int MAX_BURST  = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W      = $clog2(MAX_BURST + 1),
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              busy,
  output logic              pkt_done,
  output logic [SIZE_W-1:0] bytes_left,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              fifo_pop,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              mst_req,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [LEN_W-1:0]  mst_len,
  output logic [DATA_W-1:0] mst_wdata,
  output logic [BE_W-1:0]   mst_be,
  input  logic              mst_beat,
  input  logic              mst_done
);
  logic [LEN_W-1:0]  blen;
  logic              hold_addr;
  logic              size_wr;
  logic [SIZE_W-3:0] size_words;
  logic              addr_wr;
  logic [ADDR_W-1:0] addr_val;
  logic              xfer_end;

  pbt_regs #(
    .CFG_W(CFG_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .blen(blen), .hold_addr(hold_addr),
    .size_wr(size_wr), .size_words(size_words), .addr_wr(addr_wr),
    .addr_val(addr_val)
  );

  pbt_seq #(
    .SIZE_W(SIZE_W), .MAX_BURST(MAX_BURST), .FIFO_DEPTH(FIFO_DEPTH),
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .size_wr(size_wr), .size_words(size_words),
    .blen(blen), .fifo_count(fifo_count), .mst_beat(mst_beat),
    .mst_done(mst_done), .fifo_pop(fifo_pop), .mst_req(mst_req),
    .xfer_len(mst_len), .xfer_end(xfer_end), .busy(busy),
    .pkt_done(pkt_done), .bytes_left(bytes_left)
  );

  pbt_addr #(
    .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .busy(busy), .addr_wr(addr_wr),
    .addr_val(addr_val), .xfer_end(xfer_end), .xfer_len(mst_len),
    .hold_addr(hold_addr), .cur_addr(mst_addr)
  );

  assign mst_wdata = fifo_data;
  assign mst_be    = '1;

  AST_WDATA_IS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (mst_req && mst_beat))
    else $error("pop without accepted beat"); // R11
endmodule

// File: tb/pkt_burst_tx_test.sv
module pkt_burst_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DATA_BASE = 32'hA000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        busy, pkt_done, fifo_pop, mst_req;
  logic [15:0] bytes_left;
  logic [5:0]  fifo_count;
  logic [31:0] fifo_data, mst_addr, mst_wdata;
  logic [3:0]  mst_len, mst_be;
  logic        mst_beat = 1'b0;
  logic        mst_done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pkt_burst_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .pkt_done(pkt_done),
    .bytes_left(bytes_left), .fifo_count(fifo_count), .fifo_pop(fifo_pop),
    .fifo_data(fifo_data), .mst_req(mst_req), .mst_addr(mst_addr),
    .mst_len(mst_len), .mst_wdata(mst_wdata), .mst_be(mst_be),
    .mst_beat(mst_beat), .mst_done(mst_done)
  );

  // FIFO model
  logic [31:0] fq [0:63];
  int unsigned wp = 0;
  int unsigned rp = 0;
  int unsigned pushed = 0;
  assign fifo_count = 6'(wp - rp);
  assign fifo_data  = fq[rp % 64];
  always @(posedge clk) if (fifo_pop) rp <= rp + 1;

  // master model and beat log
  logic [31:0] log_addr [0:255];
  logic [3:0]  log_len  [0:255];
  logic [31:0] log_data [0:255];
  logic        log_be_ok [0:255];
  int          nlog = 0;
  int          tbeats = 0;
  int          done_req = 0;
  int          done_given = 0;
  logic        beat_en = 1'b1;

  always @(posedge clk) begin
    if (mst_req && mst_beat) begin
      log_addr[nlog]  = mst_addr;
      log_len[nlog]   = mst_len;
      log_data[nlog]  = mst_wdata;
      log_be_ok[nlog] = (mst_be == 4'hF);
      nlog = nlog + 1;
      tbeats = tbeats + 1;
      if (tbeats == int'(mst_len)) begin
        tbeats = 0;
        done_req = done_req + 1;
      end
    end
  end

  always @(negedge clk) begin
    mst_beat = mst_req && beat_en;
    if (done_req != done_given) begin
      mst_done = 1'b1;
      done_given = done_given + 1;
    end else begin
      mst_done = 1'b0;
    end
  end

  int checks = 0;
  int fails = 0;
  int rd_idx = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      fq[wp % 64] = DATA_BASE + 32'(pushed);
      pushed++;
      wp++;
    end
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!pkt_done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(pkt_done && !busy, tag, {pkt_done, busy}, 2'b10);
  endtask

  task automatic expect_txn(input logic [31:0] a, input int len, input string tag);
    for (int b = 0; b < len; b++) begin
      bit ok;
      ok = (rd_idx < nlog) && log_addr[rd_idx] == a && int'(log_len[rd_idx]) == len
           && log_data[rd_idx] == DATA_BASE + 32'(rd_idx) && log_be_ok[rd_idx];
      check(ok, tag, (rd_idx < nlog) ? {log_addr[rd_idx], 4'(log_len[rd_idx])} : 0,
            {a, 4'(len)});
      rd_idx++;
    end
  endtask

  task automatic expect_no_extra(input string tag);
    check(nlog == rd_idx, tag, nlog, rd_idx);
  endtask

  task automatic t_reset;
    check(!busy && !pkt_done && !mst_req, "R1 idle flags", {busy, pkt_done, mst_req}, 0);
    check(bytes_left == 0 && mst_addr == 0, "R1 counters", {bytes_left, mst_addr}, 0);
  endtask

  task automatic t_basic;
    cfg_write(2'd1, 32'h4);
    cfg_write(2'd0, 32'h1000);
    push_words(8);
    cfg_write(2'd2, 32);
    wait_done("R7 basic done");
    expect_txn(32'h1000, 4, "R6 basic burst 0");
    expect_txn(32'h1010, 4, "R6 basic burst 1");
    check(bytes_left == 0, "R3 bytes_left end", bytes_left, 0);
    expect_no_extra("R11 basic beat count");
  endtask

  task automatic t_tail;
    push_words(6);
    cfg_write(2'd2, 26);
    wait_done("R7 tail done");
    expect_txn(32'h1020, 4, "R8 continue address");
    expect_txn(32'h1030, 1, "R5 tail single 0");
    expect_txn(32'h1034, 1, "R5 tail single 1");
    expect_no_extra("R3 low size bits ignored");
  endtask

  task automatic t_stall;
    cfg_write(2'd1, 32'h8);
    cfg_write(2'd0, 32'h3002);
    push_words(5);
    cfg_write(2'd2, 32);
    check(!pkt_done && busy, "R7 done cleared by size write", {pkt_done, busy}, 2'b01);
    repeat (20) @(negedge clk);
    check(!mst_req && nlog == rd_idx, "R4 stall with short FIFO", nlog, rd_idx);
    check(bytes_left == 32, "R3 bytes_left during stall", bytes_left, 32);
    push_words(3);
    wait_done("R7 stall done");
    expect_txn(32'h3000, 8, "R4 full burst after fill");
    expect_no_extra("R11 stall beat count");
  endtask

  task automatic t_busy_ignore;
    cfg_write(2'd1, 32'h2);
    cfg_write(2'd0, 32'h4000);
    cfg_write(2'd2, 16);
    cfg_write(2'd1, 32'h18);
    cfg_write(2'd2, 400);
    cfg_write(2'd0, 32'h9000);
    check(bytes_left == 16, "R10 size write ignored", bytes_left, 16);
    push_words(4);
    wait_done("R10 busy packet done");
    expect_txn(32'h4000, 2, "R10 length kept");
    expect_txn(32'h4008, 2, "R10 hold bit ignored");
    expect_no_extra("R10 word count kept");
    push_words(1);
    cfg_write(2'd2, 4);
    wait_done("R8 follow-up done");
    expect_txn(32'h4010, 1, "R10 address write ignored");
    expect_no_extra("R11 follow-up beats");
  endtask

  task automatic t_hold;
    cfg_write(2'd1, 32'h12);
    cfg_write(2'd0, 32'h2000);
    push_words(5);
    cfg_write(2'd2, 20);
    wait_done("R7 hold done");
    expect_txn(32'h2000, 2, "R6 hold burst 0");
    expect_txn(32'h2000, 2, "R6 hold burst 1");
    expect_txn(32'h2000, 1, "R6 hold tail");
    expect_no_extra("R11 hold beats");
  endtask

  task automatic t_zero;
    cfg_write(2'd2, 3);
    check(pkt_done && !busy, "R9 tiny size done next cycle", {pkt_done, busy}, 2'b10);
    repeat (10) @(negedge clk);
    check(nlog == rd_idx && !mst_req, "R9 no request", nlog, rd_idx);
  endtask

  task automatic t_clamp;
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd0, 32'h6000);
    push_words(3);
    cfg_write(2'd2, 12);
    wait_done("R2 clamp low done");
    expect_txn(32'h6000, 1, "R2 length 0 acts as 1 a");
    expect_txn(32'h6004, 1, "R2 length 0 acts as 1 b");
    expect_txn(32'h6008, 1, "R2 length 0 acts as 1 c");
    cfg_write(2'd1, 32'hF);
    push_words(8);
    cfg_write(2'd2, 32);
    for (int k = 0; k < 40 && !pkt_done; k++) begin
      @(negedge clk);
      beat_en = (k % 3) != 1;
    end
    beat_en = 1'b1;
    wait_done("R2 clamp high done");
    expect_txn(32'h600C, 8, "R2 length 15 acts as 8, gapped beats");
    expect_no_extra("R11 gapped beats");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tail();
    t_stall();
    t_busy_ignore();
    t_hold();
    t_zero();
    t_clamp();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule